// File: doc/BRIEF.md
# Masked Vectored Interrupt Request Unit

This unit gathers six interrupt sources for an 8-bit controller core. Every trigger latches into a request register, whether or not the source is masked, so software can poll pending events. A mask register enables each source individually, and its top bit acts as a global enable. A 3-bit priority code selects one of eight fixed total orderings. The unit then names the winning source and drives the two program addresses of its vector.

The core acknowledges the interrupt it takes. That acknowledge clears the winning request bit and drops the global enable. A separate return-from-interrupt input raises the global enable again. Software reads and writes the request, mask and priority registers through a small select-and-write port. The core's start address after reset is given as a constant output that sits just past the vector table.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset, the request, mask and priority registers all read 0, `irq_pending` is low, and `reset_pc` is 0x000C.
- R2: A high `src_trig[k]` in a cycle sets request bit k at the next edge, whatever the mask holds. This also applies when software writes the request register in the same cycle.
- R3: `irq_pending` is high only when mask bit 7 (global enable) is set and at least one request bit k has mask bit k set.
- R4: Among pending enabled sources, `irq_src` is the first one in the order selected by the priority code p. For p = 0..5 the order is p, p+1, ... modulo 6. For p = 6 or 7 the order is 5, 4, 3, 2, 1, 0.
- R5: `irq_ack` while `irq_pending` is high clears the request bit of `irq_src` and clears mask bit 7 at the next edge. `irq_ack` while nothing is pending changes nothing.
- R6: `irq_ret` without `irq_ack` sets mask bit 7 at the next edge.
- R7: A write to select 0 (request) loads bits 5:0 from the write data, so a 1 sets a bit and a 0 clears it. Bits 7:6 always read 0.
- R8: The vector of source k is read high byte first. `vec_addr_hi` is 2k and `vec_addr_lo` is 2k+1.
- R9: Select 1 reads and writes the full 8-bit mask. Select 2 reads and writes the priority code in bits 2:0. Select 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_trig | input | 6 | Per-source trigger |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 request, 1 mask, 2 priority |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, selected by reg_sel |
| irq_ack | input | 1 | Core takes the pending interrupt |
| irq_ret | input | 1 | Core returns from interrupt service |
| irq_pending | output | 1 | An enabled request awaits service |
| irq_src | output | 3 | Winning source index |
| vec_addr_hi | output | 16 | Address of the vector's high byte |
| vec_addr_lo | output | 16 | Address of the vector's low byte |
| reset_pc | output | 16 | Program start address after reset |

## Verification
The bench builds the unit with its defaults: six sources, two-byte vectors and a 16-bit address. With these values the start address is 0x000C and the rotation wraps at source 5. Table rows reach rotations that wrap past source 5, the descending codes, a cleared global enable and masks that hide every raised request. Directed steps cover a trigger that collides with a software clear, and an acknowledge given with nothing pending.

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
  parameter int NSRC      = 6,
  parameter int VEC_BYTES = 2,
  parameter int AW        = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_trig,
  input  logic            reg_wr,
  input  logic [1:0]      reg_sel,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic            irq_ack,
  input  logic            irq_ret,
  output logic            irq_pending,
  output logic [2:0]      irq_src,
  output logic [AW-1:0]   vec_addr_hi,
  output logic [AW-1:0]   vec_addr_lo,
  output logic [AW-1:0]   reset_pc
);
  localparam int GEN = 7;
  localparam logic [AW-1:0] START = AW'(VEC_BYTES * NSRC);

  logic [NSRC-1:0] req_q, live, clr;
  logic [7:0]      mask_q;
  logic [2:0]      prio_q;
  logic            take;

  function automatic int slot(input logic [2:0] code, input int pos);
    if (int'(code) < NSRC) return (int'(code) + pos) % NSRC;
    return NSRC - 1 - pos;
  endfunction

  assign live        = req_q & mask_q[NSRC-1:0];
  assign irq_pending = mask_q[GEN] & (|live);
  assign take        = irq_ack & irq_pending;
  assign clr         = take ? (NSRC'(1) << irq_src) : '0;
  assign reset_pc    = START;
  assign vec_addr_hi = AW'(irq_src) * AW'(VEC_BYTES);
  assign vec_addr_lo = vec_addr_hi + AW'(1);

  always_comb begin
    irq_src = '0;
    for (int p = NSRC - 1; p >= 0; p--)
      if (live[slot(prio_q, p)]) irq_src = 3'(slot(prio_q, p));
  end

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = 8'(req_q);
      2'd1:    reg_rdata = mask_q;
      2'd2:    reg_rdata = {5'b0, prio_q};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= '0;
      mask_q <= '0;
      prio_q <= '0;
    end else begin
      req_q <= (((reg_wr && reg_sel == 2'd0) ? reg_wdata[NSRC-1:0] : req_q) & ~clr) | src_trig;
      if (reg_wr && reg_sel == 2'd1) mask_q <= reg_wdata;
      if (take)         mask_q[GEN] <= 1'b0;
      else if (irq_ret) mask_q[GEN] <= 1'b1;
      if (reg_wr && reg_sel == 2'd2) prio_q <= reg_wdata[2:0];
    end
  end

  p_trig_latches_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_trig != '0) |=> ((req_q & $past(src_trig)) == $past(src_trig)));

  p_pending_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> mask_q[GEN]);

  p_ack_drops_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_pending) |=> !mask_q[GEN]);

  p_ret_raises_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && !irq_ack) |=> mask_q[GEN]);

  p_vec_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_addr_lo == vec_addr_hi + AW'(1));

  p_winner_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> live[irq_src]);
endmodule

// File: tb/irq_vector_unit_tb.sv
module irq_vector_unit_tb;
  logic clk = 0, rst_n = 0;
  logic [5:0] src_trig = '0;
  logic reg_wr = 0, irq_ack = 0, irq_ret = 0;
  logic [1:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic irq_pending;
  logic [2:0] irq_src;
  logic [15:0] vec_addr_hi, vec_addr_lo, reset_pc;
  int total = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_vector_unit u_dut (.clk(clk), .rst_n(rst_n), .src_trig(src_trig), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ack(irq_ack),
    .irq_ret(irq_ret), .irq_pending(irq_pending), .irq_src(irq_src),
    .vec_addr_hi(vec_addr_hi), .vec_addr_lo(vec_addr_lo), .reset_pc(reset_pc));

  // {prio, mask, req, exp_pending, exp_src}
  localparam logic [22:0] TBL [0:8] = '{
    {3'd0, 8'hBF, 8'h24, 1'b1, 3'd2},
    {3'd3, 8'hBF, 8'h24, 1'b1, 3'd5},
    {3'd6, 8'hBF, 8'h05, 1'b1, 3'd2},
    {3'd7, 8'hBF, 8'h03, 1'b1, 3'd1},
    {3'd5, 8'hBF, 8'h11, 1'b1, 3'd0},
    {3'd0, 8'h3F, 8'h3F, 1'b0, 3'd0},
    {3'd0, 8'h90, 8'h0F, 1'b0, 3'd0},
    {3'd1, 8'h88, 8'h0F, 1'b1, 3'd3},
    {3'd4, 8'hA1, 8'h21, 1'b1, 3'd5}
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] d);
    reg_sel = sel; #1 d = reg_rdata;
  endtask

  task automatic pulse_ack;
    @(negedge clk); irq_ack = 1; @(negedge clk); irq_ack = 0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(2'd0, d); chk("R1 req", 16'(d), 16'h00);
    rd(2'd1, d); chk("R1 mask", 16'(d), 16'h00);
    rd(2'd2, d); chk("R1 prio", 16'(d), 16'h00);
    chk("R1 pending", 16'(irq_pending), 16'd0);
    chk("R1 reset_pc", reset_pc, 16'h000C);
    @(negedge clk); rst_n = 1;

    // R4 / R3 table walk
    foreach (TBL[i]) begin
      wr(2'd2, {5'b0, TBL[i][22:20]});
      wr(2'd1, TBL[i][19:12]);
      wr(2'd0, TBL[i][11:4]);
      chk($sformatf("R3 pending row %0d", i), 16'(irq_pending), 16'(TBL[i][3]));
      if (TBL[i][3]) begin
        chk($sformatf("R4 src row %0d", i), 16'(irq_src), 16'(TBL[i][2:0]));
        chk($sformatf("R8 hi row %0d", i), vec_addr_hi, 16'(TBL[i][2:0]) * 16'd2);
        chk($sformatf("R8 lo row %0d", i), vec_addr_lo, 16'(TBL[i][2:0]) * 16'd2 + 16'd1);
      end
    end

    // R9 register readback
    rd(2'd2, d); chk("R9 prio read", 16'(d), 16'h04);
    rd(2'd1, d); chk("R9 mask read", 16'(d), 16'hA1);
    rd(2'd3, d); chk("R9 sel3 read", 16'(d), 16'h00);

    // R2 masked trigger still latches
    wr(2'd1, 8'h00); wr(2'd0, 8'h00);
    @(negedge clk); src_trig = 6'h08; @(negedge clk); src_trig = '0;
    rd(2'd0, d); chk("R2 masked latch", 16'(d), 16'h08);
    chk("R3 masked no pend", 16'(irq_pending), 16'd0);

    // R7 software write set/clear
    wr(2'd0, 8'h00); rd(2'd0, d); chk("R7 clear", 16'(d), 16'h00);
    wr(2'd0, 8'hFF); rd(2'd0, d); chk("R7 set upper zero", 16'(d), 16'h3F);

    // R2 trigger beats simultaneous clear
    @(negedge clk); reg_wr = 1; reg_sel = 2'd0; reg_wdata = 8'h00; src_trig = 6'h02;
    @(negedge clk); reg_wr = 0; src_trig = '0;
    rd(2'd0, d); chk("R2 trig vs write", 16'(d), 16'h02);

    // R5 acknowledge
    wr(2'd2, 8'h00); wr(2'd1, 8'h84); wr(2'd0, 8'h24);
    chk("R4 src before ack", 16'(irq_src), 16'd2);
    pulse_ack();
    rd(2'd0, d); chk("R5 req cleared", 16'(d), 16'h20);
    rd(2'd1, d); chk("R5 enable cleared", 16'(d), 16'h04);
    chk("R5 no pending", 16'(irq_pending), 16'd0);

    // R6 return
    @(negedge clk); irq_ret = 1; @(negedge clk); irq_ret = 0;
    rd(2'd1, d); chk("R6 enable set", 16'(d), 16'h84);

    // R5 ack with nothing pending is ignored
    wr(2'd0, 8'h00);
    pulse_ack();
    rd(2'd1, d); chk("R5 idle ack mask", 16'(d), 16'h84);
    rd(2'd0, d); chk("R5 idle ack req", 16'(d), 16'h00);

    // R8 highest source vector
    wr(2'd1, 8'hA0); wr(2'd0, 8'h20);
    chk("R8 src5 hi", vec_addr_hi, 16'd10);
    chk("R8 src5 lo", vec_addr_lo, 16'd11);

    done = 1;
    summary();
    $finish;
  end
endmodule